// File: doc/BRIEF.md
# EPROM Identifier Reader

This controller reads the two identification bytes of a byte-wide UV-erasable memory before a programmer starts writing to it. A single `start` pulse begins a run. The controller raises a request for the identifier high voltage on the memory's designated address pin. While that request is high, it holds every other address line low and asserts both read strobes. It then reads the manufacturer byte with address bit 0 low and the device byte with address bit 0 high. Each read waits a programmable settle time before sampling.

After the second byte is captured, the high-voltage request and the strobes are released and `done` pulses for one cycle. The captured bytes stay on the outputs until the next run captures new ones. Two separate flags come with them:

- a mismatch-versus-expected indication;
- a parity fault. Each genuine identifier byte carries odd parity across all eight bits, and bit 7 is the parity bit.

Generating the high voltage and choosing a programming algorithm are left to the surrounding logic.

Top module: `eprom_id_reader`

## Requirements
- R1: After reset, `id_hv_req_o` is 0, `ce_n_o` and `oe_n_o` are 1, `addr_o` is all zero, `done_o` is 0, and both codes and both flags are 0.
- R2: In the cycle after `start_i` is sampled high in idle:
  - `id_hv_req_o` is 1;
  - `ce_n_o` and `oe_n_o` are both 0;
  - every bit of `addr_o` is 0, so the manufacturer byte is selected.
- R3: Each read phase lasts exactly `SETTLE_CYC` cycles. The data bus is sampled only at the clock edge that ends the last cycle of the phase, never earlier.
- R4: In the second phase:
  - `addr_o[0]` is 1 and all higher address bits stay 0;
  - `id_hv_req_o` stays 1, and both strobes stay 0;
  - the byte sampled at the end of this phase becomes the device code.
- R5: `done_o` goes high 2*`SETTLE_CYC`+1 clock edges after the edge that sampled `start_i`, counting that edge as the first. It stays high for exactly one cycle. While `done_o` is high, `id_hv_req_o` is 0 and both strobes are 1.
- R6: `mfr_code_o` and `dev_code_o` show the bytes captured in phase 1 and phase 2, from the `done_o` cycle until the next run captures new ones.
- R7: `parity_err_o` is 1 exactly when at least one captured byte has an even number of 1 bits. Bit 7 of each byte is its parity bit.
- R8: `match_o` is 1 exactly when the manufacturer byte equals `EXP_MFR` (default 01h) and the device byte equals `EXP_DEV` (default 1Ch). It does not depend on `parity_err_o`.
- R9: A `start_i` pulse while a run is in progress is ignored. The run keeps its timing, and only one `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an identification run (sampled in idle only) |
| id_hv_req_o | output | 1 | Request for identifier high voltage on the memory's designated address pin |
| addr_o | output | ADDR_W | Memory address lines; only bit 0 ever toggles |
| ce_n_o | output | 1 | Memory chip enable, active low |
| oe_n_o | output | 1 | Memory output enable, active low |
| dq_i | input | 8 | Memory data bus |
| mfr_code_o | output | 8 | Captured manufacturer byte |
| dev_code_o | output | 8 | Captured device byte |
| match_o | output | 1 | Both bytes equal the expected values |
| parity_err_o | output | 1 | At least one byte has even parity |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives the controller against a memory model that returns the identifier bytes only when all of the following hold:
- the high-voltage request is up and both strobes are low;
- all upper address lines are low;
- the pins have been steady for the full settle time.

Any other combination returns a filler byte. Sampling too early, or with the wrong address pattern, therefore shows up as wrong codes. The byte pairs are chosen to separate the two flags:
- a correct pair;
- a parity-clean pair that does not match;
- pairs where only the first byte, or only the second byte, has even parity;
- an even-parity byte that differs from the expected value in one bit.

Together these show that each byte feeds each flag on its own and that the flags do not depend on each other. A further directed run pulses start in the middle of a read, to show that the run is neither restarted nor repeated.

// File: rtl/idr_pkg.sv
package idr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MFR  = 2'd1,
    ST_DEV  = 2'd2,
    ST_DONE = 2'd3
  } idr_state_e;

  localparam int unsigned ID_BYTES = 2;
  localparam int unsigned ID_W     = 8;

  // Odd number of ones means the byte carries valid identifier parity.
  function automatic logic parity_ok(input logic [ID_W-1:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/idr_settle_timer.sv
module idr_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned LAST  = SETTLE_CYC - 1;
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || expired_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !expired_o) |=> (cnt_q != '0)); // R3

endmodule

// File: rtl/idr_code_check.sv
module idr_code_check
  import idr_pkg::*;
#(
  parameter logic [ID_W-1:0] EXP_MFR = 8'h01,
  parameter logic [ID_W-1:0] EXP_DEV = 8'h1C
) (
  input  logic [ID_W-1:0] mfr_i,
  input  logic [ID_W-1:0] dev_i,
  output logic            match_o,
  output logic            parity_err_o
);
  logic [ID_W-1:0]     got [ID_BYTES];
  logic [ID_W-1:0]     want[ID_BYTES];
  logic [ID_BYTES-1:0] bad_par;
  logic [ID_BYTES-1:0] same;

  assign got[0]  = mfr_i;
  assign got[1]  = dev_i;
  assign want[0] = EXP_MFR;
  assign want[1] = EXP_DEV;

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_byte
    assign bad_par[i] = !parity_ok(got[i]);
    assign same[i]    = (got[i] == want[i]);
  end

  assign match_o      = &same;
  assign parity_err_o = |bad_par;

endmodule

// File: rtl/idr_seq.sv
module idr_seq
  import idr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic expired_i,
  output logic run_o,
  output logic a0_o,
  output logic hv_req_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic cap_mfr_o,
  output logic cap_dev_o,
  output logic done_o
);
  idr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_MFR;
      ST_MFR:  if (expired_i) state_d = ST_DEV;
      ST_DEV:  if (expired_i) state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign hv_req_o  = (state_q == ST_MFR) || (state_q == ST_DEV);
  assign run_o     = hv_req_o;
  assign a0_o      = (state_q == ST_DEV);
  assign ce_n_o    = !hv_req_o;
  assign oe_n_o    = !hv_req_o;
  assign cap_mfr_o = (state_q == ST_MFR) && expired_i;
  assign cap_dev_o = (state_q == ST_DEV) && expired_i;
  assign done_o    = (state_q == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!hv_req_o && ce_n_o && oe_n_o)); // R5

  AST_A0_AFTER_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a0_o) |-> $past(cap_mfr_o)); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV) |=> (state_q != ST_MFR)); // R9

  AST_CAPTURE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mfr_o || cap_dev_o) |-> (!ce_n_o && !oe_n_o)); // R2

endmodule

// File: rtl/eprom_id_reader.sv
module eprom_id_reader
  import idr_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 20,
  parameter int unsigned      SETTLE_CYC = 4,
  parameter logic [ID_W-1:0]  EXP_MFR    = 8'h01,
  parameter logic [ID_W-1:0]  EXP_DEV    = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              id_hv_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  input  logic [ID_W-1:0]   dq_i,
  output logic [ID_W-1:0]   mfr_code_o,
  output logic [ID_W-1:0]   dev_code_o,
  output logic              match_o,
  output logic              parity_err_o,
  output logic              done_o
);
  localparam int unsigned UPPER_W = ADDR_W - 1;

  logic run, expired, a0, cap_mfr, cap_dev;
  logic match_w, par_err_w;
  logic [ID_W-1:0] mfr_q, dev_q;
  logic match_q, par_err_q;

  idr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .expired_o (expired)
  );

  idr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expired_i (expired),
    .run_o     (run),
    .a0_o      (a0),
    .hv_req_o  (id_hv_req_o),
    .ce_n_o    (ce_n_o),
    .oe_n_o    (oe_n_o),
    .cap_mfr_o (cap_mfr),
    .cap_dev_o (cap_dev),
    .done_o    (done_o)
  );

  // Flags are judged on the stored manufacturer byte and the device byte on the bus.
  idr_code_check #(.EXP_MFR(EXP_MFR), .EXP_DEV(EXP_DEV)) u_check (
    .mfr_i        (mfr_q),
    .dev_i        (dq_i),
    .match_o      (match_w),
    .parity_err_o (par_err_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mfr_q     <= '0;
      dev_q     <= '0;
      match_q   <= 1'b0;
      par_err_q <= 1'b0;
    end else begin
      if (cap_mfr) mfr_q <= dq_i;
      if (cap_dev) begin
        dev_q     <= dq_i;
        match_q   <= match_w;
        par_err_q <= par_err_w;
      end
    end
  end

  assign addr_o       = {{UPPER_W{1'b0}}, a0};
  assign mfr_code_o   = mfr_q;
  assign dev_code_o   = dev_q;
  assign match_o      = match_q;
  assign parity_err_o = par_err_q;

  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || !id_hv_req_o) |=> $stable(dev_code_o)); // R6

  AST_MATCH_NEEDS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && match_o) |-> (mfr_code_o == EXP_MFR && dev_code_o == EXP_DEV)); // R8

endmodule

// File: tb/test_eprom_id_reader.sv
`timescale 1ns/1ps
module test_eprom_id_reader;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned S      = 4;
  localparam int unsigned NVEC   = 6;

  // {mfr, dev, expected match, expected parity error}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h01, 8'h1C, 1'b1, 1'b0},
    {8'h02, 8'h1C, 1'b0, 1'b0},
    {8'h81, 8'h1C, 1'b0, 1'b1},
    {8'h01, 8'h9C, 1'b0, 1'b1},
    {8'h01, 8'h1D, 1'b0, 1'b1},
    {8'h80, 8'h0E, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic id_hv_req, ce_n, oe_n, match, parity_err, done;
  logic [ADDR_W-1:0] addr;
  logic [7:0] dq = 8'h5A;
  logic [7:0] mfr_code, dev_code;
  logic [7:0] mdl_mfr = 8'h00, mdl_dev = 8'h00;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eprom_id_reader #(.ADDR_W(ADDR_W), .SETTLE_CYC(S)) i_eprom_id_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .id_hv_req_o(id_hv_req),
    .addr_o(addr), .ce_n_o(ce_n), .oe_n_o(oe_n), .dq_i(dq),
    .mfr_code_o(mfr_code), .dev_code_o(dev_code), .match_o(match),
    .parity_err_o(parity_err), .done_o(done)
  );

  // Memory model: identifier bytes only after pins have been steady for S-1 negedges.
  initial begin
    logic [ADDR_W+2:0] prev = '0;
    int steady = 0;
    forever begin
      @(negedge clk);
      if ({id_hv_req, ce_n, oe_n, addr} != prev) steady = 0;
      else if (steady < 1000) steady++;
      prev = {id_hv_req, ce_n, oe_n, addr};
      if (id_hv_req && !ce_n && !oe_n && addr[ADDR_W-1:1] == '0 && steady >= S - 1)
        dq = addr[0] ? mdl_dev : mdl_mfr;
      else
        dq = 8'h5A;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_id(input logic [7:0] m, input logic [7:0] d, input bit extra, output int lat);
    mdl_mfr = m;
    mdl_dev = d;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 1;
    check("R2 hv/strobes/addr in phase 1", {id_hv_req, ce_n, oe_n, addr}, {1'b1, 1'b0, 1'b0, {ADDR_W{1'b0}}});
    while (!done && lat < 60) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = (extra && lat == S + 2);
      if (lat == S + 1)
        check("R4 phase 2 addr/hv", {id_hv_req, ce_n, oe_n, addr}, {1'b1, 1'b0, 1'b0, {(ADDR_W-1){1'b0}}, 1'b1});
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int extra_done;
    repeat (3) @(negedge clk);
    check("R1 reset pins", {id_hv_req, ce_n, oe_n, done, addr}, {1'b0, 1'b1, 1'b1, 1'b0, {ADDR_W{1'b0}}});
    check("R1 reset results", {mfr_code, dev_code, match, parity_err}, 18'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {id_hv_req, done}, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      run_id(VEC[i][17:10], VEC[i][9:2], 1'b0, lat);
      check("R5 latency", lat, 2 * S + 1);
      check("R5 release at done", {done, id_hv_req, ce_n, oe_n}, 4'b1011);
      check("R3 R6 mfr code", mfr_code, VEC[i][17:10]);
      check("R4 R6 dev code", dev_code, VEC[i][9:2]);
      check("R8 match", match, VEC[i][1]);
      check("R7 parity error", parity_err, VEC[i][0]);
      mdl_mfr = 8'hFF;
      mdl_dev = 8'hFF;
      @(negedge clk);
      check("R5 done one cycle", done, 1'b0);
      repeat (3) @(negedge clk);
      check("R6 codes held", {mfr_code, dev_code, match, parity_err}, {VEC[i][17:2], VEC[i][1], VEC[i][0]});
    end

    // R9: start pulse during the run has no effect
    run_id(8'h01, 8'h1C, 1'b1, lat);
    check("R9 latency unchanged", lat, 2 * S + 1);
    check("R9 codes", {mfr_code, dev_code, match, parity_err}, {8'h01, 8'h1C, 1'b1, 1'b0});
    extra_done = 0;
    for (int k = 0; k < 3 * S + 4; k++) begin
      @(negedge clk);
      if (done) extra_done++;
    end
    check("R9 single done", extra_done, 0);
    check("R9 stays idle", {id_hv_req, ce_n, oe_n}, 3'b011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule